// File: doc/BRIEF.md
# Serial 1001 Detector with Seven-Segment Output and Display Test Path

This block samples one serial input bit on every rising clock edge and tracks the most recent bits with a five-state Moore machine. When the four latest bits, oldest first, are 1, 0, 0, 1, the machine sits in its match state. The final 1 of a match may also open the next match, so overlapping occurrences are reported. A registered seven-segment output shows "8." (all segments and the decimal point) while the machine is in its match state, and only the middle dash otherwise. The block is meant for a slow clock of about 1 Hz, one input bit per clock.

A 7-bit condition input selects the display test path, but only when every bit of it is 1. In that mode an 8-bit test word drives the display instead of the detector. Its upper nibble picks the sub-mode and its lower nibble the value: either a decimal digit or one single lit segment. The detector keeps running while the test path is shown.

Top module: `seqdet_display`

## Requirements
- R1: The machine enters its match state on the clock edge that samples the 1 completing the serial pattern 1, 0, 0, 1. Overlap is allowed: 1001001 gives two matches, and no other pattern gives one.
- R2: The segment output uses a=bit0 through g=bit6 and the decimal point at bit7, all active high. Outside test mode, one clock edge after the machine state, it reads 8'hFF in the match state and 8'h40 in every other state.
- R3: Test mode is active only when the condition input equals 7'b1111111. Every other value, including 7'b1111110 and 7'b0111111, shows the detector.
- R4: In test mode with test word bits [7:4] = 4'b0000, bits [3:0] = 0..9 show the digit codes 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R5: In test mode with bits [7:4] = 4'b0000, values 10..15 in bits [3:0] blank the output (8'h00).
- R6: In test mode with bits [7:4] = 4'b1111, a value n = 0..7 in bits [3:0] gives exactly bit n set (8'h01 << n).
- R7: In test mode with bits [7:4] = 4'b1111, values 8..15 in bits [3:0] blank the output.
- R8: In test mode, any upper nibble other than 4'b0000 or 4'b1111 blanks the output.
- R9: While rst_ni is low, the output is 8'h40 and the machine is idle. The serial input has no effect during reset, so a match needs four new bits after release.
- R10: The machine keeps consuming serial bits while test mode is shown. On return to normal mode, the output reflects the pattern received during test mode.
- R11: Every output change occurs on a rising clock edge: the output follows a change of condition or test word one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one serial bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial data bit |
| cond_i | input | COND_W (7) | Test mode select, all ones enables test path |
| test_i | input | 2*NIB_W (8) | Test word: sub-mode nibble high, value nibble low |
| seg_o | output | 8 | Registered seven-segment drive, dp at bit 7 |

## Verification
The bench builds the block with its default widths: a 7-bit condition and 4-bit nibbles. This makes every sub-mode and value combination reachable, including all sixteen digit values and all sixteen segment indices, so the blanking cases past the last digit and past the last segment are exercised. The widths also allow near-miss condition codes one bit short of all ones. A shift-register model of the last four serial bits predicts each match independently of the state machine. It covers overlapping runs, long random streams, bits fed during test mode and a reset applied mid-stream.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int unsigned SEG_W = 8;

  localparam logic [SEG_W-1:0] SEG_FULL  = 8'hFF;
  localparam logic [SEG_W-1:0] SEG_DASH  = 8'h40;
  localparam logic [SEG_W-1:0] SEG_BLANK = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S10  = 3'd2,
    ST_S100 = 3'd3,
    ST_HIT  = 3'd4
  } det_state_e;

  // a=bit0 .. g=bit6, dp=bit7
  function automatic logic [SEG_W-1:0] digit_code(input int unsigned val);
    logic [SEG_W-1:0] code;
    case (val)
      0:       code = 8'h3F;
      1:       code = 8'h06;
      2:       code = 8'h5B;
      3:       code = 8'h4F;
      4:       code = 8'h66;
      5:       code = 8'h6D;
      6:       code = 8'h7D;
      7:       code = 8'h07;
      8:       code = 8'h7F;
      9:       code = 8'h6F;
      default: code = SEG_BLANK;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/seqdet_fsm.sv
module seqdet_fsm
  import seqdet_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic det_o
);

  det_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = x_i ? ST_S1   : ST_IDLE;
      ST_S1:   state_d = x_i ? ST_S1   : ST_S10;
      ST_S10:  state_d = x_i ? ST_S1   : ST_S100;
      ST_S100: state_d = x_i ? ST_HIT  : ST_IDLE;
      ST_HIT:  state_d = x_i ? ST_S1   : ST_S10;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign det_o = (state_q == ST_HIT);

endmodule

// File: rtl/seqdet_seg_enc.sv
module seqdet_seg_enc
  import seqdet_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  logic [NIB_W-1:0] mode_i,
  input  logic [NIB_W-1:0] val_i,
  output logic [SEG_W-1:0] seg_o
);

  logic [SEG_W-1:0] single_seg;
  logic [SEG_W-1:0] digit_seg;

  // one lit segment per index; indices past SEG_W match no bit
  for (genvar i = 0; i < SEG_W; i++) begin : g_single
    assign single_seg[i] = (val_i == NIB_W'(i));
  end

  assign digit_seg = digit_code(int'(val_i));

  always_comb begin
    if (mode_i == '0)      seg_o = digit_seg;
    else if (&mode_i)      seg_o = single_seg;
    else                   seg_o = SEG_BLANK;
  end

endmodule

// File: rtl/seqdet_out_reg.sv
module seqdet_out_reg
  import seqdet_pkg::*;
#(
  parameter int unsigned COND_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COND_W-1:0] cond_i,
  input  logic              det_i,
  input  logic [SEG_W-1:0]  test_seg_i,
  output logic [SEG_W-1:0]  seg_o
);

  logic             test_mode;
  logic [SEG_W-1:0] seg_d;

  assign test_mode = &cond_i;

  always_comb begin
    if (test_mode) seg_d = test_seg_i;
    else           seg_d = det_i ? SEG_FULL : SEG_DASH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_o <= SEG_DASH;
    else         seg_o <= seg_d;
  end

endmodule

// File: rtl/seqdet_display.sv
module seqdet_display
  import seqdet_pkg::*;
#(
  parameter int unsigned COND_W = 7,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned TEST_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [TEST_W-1:0] test_i,
  output logic [SEG_W-1:0]  seg_o
);

  logic             det;
  logic [SEG_W-1:0] test_seg;

  seqdet_fsm u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (x_i),
    .det_o (det)
  );

  seqdet_seg_enc #(.NIB_W(NIB_W)) u_enc (
    .mode_i(test_i[TEST_W-1:NIB_W]),
    .val_i (test_i[NIB_W-1:0]),
    .seg_o (test_seg)
  );

  seqdet_out_reg #(.COND_W(COND_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (cond_i),
    .det_i     (det),
    .test_seg_i(test_seg),
    .seg_o     (seg_o)
  );

endmodule

// File: rtl/seqdet_display_chk.sv
module seqdet_display_chk #(
  parameter int unsigned COND_W = 7,
  parameter int unsigned NIB_W  = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 x_i,
  input logic [COND_W-1:0]    cond_i,
  input logic [2*NIB_W-1:0]   test_i,
  input logic                 det_i,
  input logic [7:0]           seg_i
);

  logic [1:0] age_q;
  logic       tmode;
  logic [NIB_W-1:0] hi;

  assign tmode = &cond_i;
  assign hi    = test_i[2*NIB_W-1:NIB_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  pattern_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && x_i && !$past(x_i) && !$past(x_i, 2) && $past(x_i, 3)) |=> det_i);

  // R2
  normal_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmode && det_i) |=> (seg_i == 8'hFF));

  // R2
  normal_dash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmode && !det_i) |=> (seg_i == 8'h40));

  // R6
  single_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmode && (&hi)) |=> $onehot0(seg_i));

  // R8
  bad_mode_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmode && hi != '0 && !(&hi)) |=> (seg_i == 8'h00));

  // R9
  reset_dash_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (seg_i == 8'h40));

endmodule

bind seqdet_display seqdet_display_chk #(.COND_W(COND_W), .NIB_W(NIB_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .x_i   (x_i),
  .cond_i(cond_i),
  .test_i(test_i),
  .det_i (det),
  .seg_i (seg_o)
);

// File: tb/seqdet_display_tb.sv
module seqdet_display_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       x_i;
  logic [6:0] cond_i;
  logic [7:0] test_i;
  logic [7:0] seg_o;

  int checks = 0;
  int fails  = 0;
  logic [3:0] hist = 4'b0000;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #2 clk_i = ~clk_i;

  seqdet_display u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (x_i),
    .cond_i(cond_i),
    .test_i(test_i),
    .seg_o (seg_o)
  );

  function automatic logic [7:0] model(input logic [3:0] h, input logic [6:0] c,
                                       input logic [7:0] t);
    logic [7:0] dig [10] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66,
                             8'h6D, 8'h7D, 8'h07, 8'h7F, 8'h6F};
    if (c != 7'h7F) return (h == 4'b1001) ? 8'hFF : 8'h40;
    if (t[7:4] == 4'h0) return (t[3:0] < 10) ? dig[t[3:0]] : 8'h00;
    if (t[7:4] == 4'hF) return (t[3:0] < 8) ? (8'h01 << t[3:0]) : 8'h00;
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: seg_o=%h expected %h", tag, act, exp);
    end
  endtask

  // driver: one serial bit per clock, expected value queued for the next edge
  task automatic step(input logic x, input logic [6:0] c, input logic [7:0] t,
                      input string tag);
    @(negedge clk_i);
    x_i = x; cond_i = c; test_i = t;
    exp_q.push_back(model(hist, c, t));
    tag_q.push_back(tag);
    hist = {hist[2:0], x};
  endtask

  task automatic bits(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) step(s[i] == "1", 7'h00, 8'h00, tag);
  endtask

  task automatic drain();
    @(posedge clk_i); #1;
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && exp_q.size() > 0) check(tag_q.pop_front(), seg_o, exp_q.pop_front());
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: timeout actual=running expected=done");
      summary();
    end
  end

  initial begin
    rst_ni = 1'b0; x_i = 1'b1; cond_i = 7'h7F; test_i = 8'h08;
    // R9: x and test mode ignored during reset
    repeat (3) begin
      @(negedge clk_i); x_i = ~x_i;
      check("R9 reset", seg_o, 8'h40);
    end
    @(negedge clk_i); x_i = 1'b0; cond_i = 7'h00; rst_ni = 1'b1;
    hist = 4'b0000;

    bits("001", "R9 no carry from reset");
    bits("1001001", "R1 overlap");
    bits("1100110", "R1 R2");
    bits("1010010001", "R1 near miss");
    for (int i = 0; i < 300; i++) step(1'($urandom_range(1)), 7'h00, 8'h00, "R1 random");

    // R3: near-miss conditions keep the detector display
    bits("100", "R3 prefix");
    step(1'b1, 7'h7E, 8'h08, "R3 cond 7E");
    step(1'b0, 7'h3F, 8'hF0, "R3 cond 3F");
    step(1'b0, 7'h5F, 8'h00, "R3 cond 5F");

    for (int v = 0; v < 16; v++)
      step(1'b0, 7'h7F, {4'h0, 4'(v)}, (v < 10) ? "R4 digit" : "R5 digit blank");
    for (int v = 0; v < 16; v++)
      step(1'b0, 7'h7F, {4'hF, 4'(v)}, (v < 8) ? "R6 single seg" : "R7 seg blank");
    for (int m = 1; m < 15; m++)
      step(1'b0, 7'h7F, {4'(m), 4'h3}, "R8 bad mode");

    // R10: pattern fed while test path shown, then back to normal
    step(1'b1, 7'h7F, 8'h05, "R10 test");
    step(1'b0, 7'h7F, 8'h05, "R10 test");
    step(1'b0, 7'h7F, 8'hF2, "R10 test");
    step(1'b1, 7'h7F, 8'hF2, "R10 test");
    step(1'b0, 7'h00, 8'h00, "R10 back to normal");
    step(1'b0, 7'h00, 8'h00, "R10 normal");

    // R11: output tracks test word one edge later
    step(1'b0, 7'h7F, 8'h01, "R11 first");
    step(1'b0, 7'h7F, 8'h07, "R11 change");
    step(1'b0, 7'h00, 8'h07, "R11 leave test");
    drain();

    // R9: mid-stream reset
    bits("100", "R9 pre reset");
    drain();
    @(negedge clk_i); rst_ni = 1'b0; x_i = 1'b1;
    #1 check("R9 async reset", seg_o, 8'h40);
    @(negedge clk_i); x_i = 1'b0; rst_ni = 1'b1;
    hist = 4'b0000;
    check("R9 after reset", seg_o, 8'h40);
    bits("1001", "R9 fresh match");
    bits("00", "R2 after match");
    drain();

    done = 1'b1;
    summary();
  end

endmodule